// File: doc/BRIEF.md
# Morton-Tiled Image Address Generator

The block walks an image pixel by pixel in raster order and produces, for each pixel, the byte address the pixel occupies in a GPU tiled layout. The image is cut into tiles of 16384 bytes each. A tile's pixel shape depends on the pixel size, tiles follow one another left to right and then top to bottom, and inside a tile the pixels are stored in Z (Morton) order. When the compressed layout is selected, the block also gives the address of the 8-byte metadata entry that covers the pixel's 16x16 subtile. That metadata section starts right after the 128-byte-padded body.

Software or a DMA sequencer sets the image width, height, pixel size code, layout flag and base address, then pulses `start`. Addresses leave on a valid/ready stream, and `out_last` marks the final pixel. The body size, the metadata start and the nominal row stride are held as registered outputs for the rest of the walk and until the next accepted start.

Top module: `tile_addr_gen`

## Requirements
- R1: The pixel size code `c` (0..4) means 2^c bytes per pixel. The tile shape in pixels is 128x128 for c=0, 128x64 for c=1, 64x64 for c=2, 64x32 for c=3 and 32x32 for c=4. The pixel address is base + (tile row × tiles per row + tile column) × 16384 + (in-tile index × 2^c), with tiles per row = ceil(width / tile width).
- R2: The in-tile index puts in-tile x bit i at index bit 2i and in-tile y bit i at index bit 2i+1. When the tile is twice as wide as tall, the one remaining x bit takes the top index position.
- R3: Pixels come out with x running fastest, then y, and there are exactly width × height beats. `out_last` is high on the final beat only, and `busy` drops once that beat is accepted.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_meta` and `out_last` hold their values.
- R5: A start whose base has any of bits [6:0] set is refused. `cfg_err` goes high, no walk starts and no beat appears. The next accepted start clears `cfg_err`.
- R6: A start with a size code above 4, a zero width or a zero height is refused in the same way.
- R7: A `start` pulse while `busy` is high is ignored. The running walk and its geometry outputs stay unchanged.
- R8: `geo_stride` equals width × 2^c.
- R9: `geo_body_size` is tiles per row × tile rows × 16384, rounded up to a multiple of 128. `geo_meta_base` equals base + `geo_body_size`.
- R10: In the compressed layout, `out_meta` is `geo_meta_base` + 8 × Z-index of the subtile (x>>4, y>>4). The subtile grid uses width and height rounded up to powers of two, each divided by 16 with a minimum of 1. The Z-index interleaves x in the even bits and y in the odd bits over the shorter side, then packs the longer side's remaining bits above them. In the plain layout `out_meta` is 0.
- R11: After reset, `out_valid`, `busy` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| cfg_width | input | DIM_W | Image width in pixels |
| cfg_height | input | DIM_W | Image height in pixels |
| cfg_bpp_code | input | 3 | log2 of bytes per pixel, 0..4 |
| cfg_compressed | input | 1 | Selects the layout with a metadata section |
| cfg_base | input | ADDR_W | Image base byte address, 128-byte aligned |
| busy | output | 1 | A walk is in progress |
| cfg_err | output | 1 | Last start was refused |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream beat accepted |
| out_addr | output | ADDR_W | Pixel byte address |
| out_meta | output | ADDR_W | Metadata entry address (0 in the plain layout) |
| out_last | output | 1 | Final pixel of the image |
| geo_stride | output | DIM_W+4 | Width × bytes per pixel |
| geo_body_size | output | ADDR_W | Padded body size in bytes |
| geo_meta_base | output | ADDR_W | Metadata section start address |

## Verification
A wrong coordinate counter or tile-shape choice shows up in the very first beat whose address crosses a tile or a Z-order bit boundary. The stream is compared beat by beat, so a fault is reported within the image row where it happens. A stall fault shows on the beat after the stall: the held address changes, or a beat is lost and the beat count no longer matches. Faults in the geometry path (row count, padding, grid rounding) show in the size outputs and in every metadata address of a compressed walk. The error path is checked by the absence of any beat and by `busy` staying low.

// File: rtl/tmap_pkg.sv
package tmap_pkg;

  localparam int unsigned TILE_BYTES_LOG2 = 14;
  localparam int unsigned SUBTILE_LOG2    = 4;
  localparam int unsigned META_ENTRY_LOG2 = 3;
  localparam int unsigned ALIGN_LOG2      = 7;
  localparam int unsigned SIDE_MAX_LOG2   = 7;
  localparam int unsigned GRID_BITS       = 16;
  localparam logic [2:0]  CODE_MAX        = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } walk_st_e;

  // tile width log2: 7,7,6,6,5 for codes 0..4
  function automatic logic [2:0] side_w_log2(input logic [2:0] code);
    return 3'd7 - {1'b0, code[2:1]};
  endfunction

  // tile height log2: 7,6,6,5,5 for codes 0..4
  function automatic logic [2:0] side_h_log2(input logic [2:0] code);
    logic [2:0] t;
    t = code + 3'd1;
    return 3'd7 - {1'b0, t[2:1]};
  endfunction

  function automatic logic [5:0] ceil_log2(input logic [31:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if ((64'd1 << i) < {32'd0, v}) r = 6'(i + 1);
    end
    return r;
  endfunction

  // interleave masked in-tile coordinates; x feeds even bits
  function automatic logic [2*SIDE_MAX_LOG2-1:0] tile_zorder(
    input logic [SIDE_MAX_LOG2-1:0] x,
    input logic [SIDE_MAX_LOG2-1:0] y,
    input logic [2:0] wl,
    input logic [2:0] hl);
    logic [2*SIDE_MAX_LOG2-1:0] r;
    r = '0;
    for (int i = 0; i < int'(SIDE_MAX_LOG2); i++) begin
      if (i < int'(wl)) r[2*i]   = x[i];
      if (i < int'(hl)) r[2*i+1] = y[i];
    end
    return r;
  endfunction

  // Z-index over a power-of-two grid of 2^a by 2^b cells
  function automatic logic [2*GRID_BITS-1:0] grid_zorder(
    input logic [GRID_BITS-1:0] sx,
    input logic [GRID_BITS-1:0] sy,
    input logic [4:0] a,
    input logic [4:0] b);
    logic [2*GRID_BITS-1:0] r;
    int m;
    r = '0;
    m = (a < b) ? int'(a) : int'(b);
    for (int i = 0; i < int'(GRID_BITS); i++) begin
      if (i < m) begin
        r[2*i]   = sx[i];
        r[2*i+1] = sy[i];
      end else begin
        if (i < int'(a)) r[m+i] = sx[i];
        if (i < int'(b)) r[m+i] = sy[i];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tmap_geom.sv
module tmap_geom
  import tmap_pkg::*;
#(
  parameter int DIM_W  = 13,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DIM_W-1:0]  in_width,
  input  logic [DIM_W-1:0]  in_height,
  input  logic [2:0]        in_code,
  input  logic              in_comp,
  input  logic [ADDR_W-1:0] in_base,
  output logic [DIM_W-1:0]  width_q,
  output logic [DIM_W-1:0]  height_q,
  output logic [2:0]        code_q,
  output logic              comp_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [2:0]        tw_q,
  output logic [2:0]        th_q,
  output logic [DIM_W-1:0]  tpr_q,
  output logic [4:0]        ga_q,
  output logic [4:0]        gb_q,
  output logic [DIM_W+3:0]  stride_q,
  output logic [ADDR_W-1:0] body_q,
  output logic [ADDR_W-1:0] meta_base_q
);

  localparam int PROD_W = 2 * DIM_W;
  localparam logic [ADDR_W-1:0] PAD_MASK = ADDR_W'((1 << ALIGN_LOG2) - 1);

  logic [2:0]        tw_c, th_c;
  logic [DIM_W:0]    wsum, hsum;
  logic [DIM_W-1:0]  tpr_c, trows_c;
  logic [PROD_W-1:0] tiles_c;
  logic [ADDR_W-1:0] body_raw, body_c;
  logic [5:0]        clw, clh;
  logic [4:0]        ga_c, gb_c;

  // stage 1: capture the request
  always_ff @(posedge clk) begin
    if (rst) begin
      width_q  <= '0;
      height_q <= '0;
      code_q   <= '0;
      comp_q   <= 1'b0;
      base_q   <= '0;
    end else if (load) begin
      width_q  <= in_width;
      height_q <= in_height;
      code_q   <= in_code;
      comp_q   <= in_comp;
      base_q   <= in_base;
    end
  end

  always_comb begin
    tw_c     = side_w_log2(code_q);
    th_c     = side_h_log2(code_q);
    wsum     = {1'b0, width_q}  + ((DIM_W+1)'(1) << tw_c) - (DIM_W+1)'(1);
    hsum     = {1'b0, height_q} + ((DIM_W+1)'(1) << th_c) - (DIM_W+1)'(1);
    tpr_c    = DIM_W'(wsum >> tw_c);
    trows_c  = DIM_W'(hsum >> th_c);
    tiles_c  = PROD_W'(tpr_c) * PROD_W'(trows_c);
    body_raw = ADDR_W'(tiles_c) << TILE_BYTES_LOG2;
    body_c   = (body_raw + PAD_MASK) & ~PAD_MASK;
    clw      = ceil_log2(32'(width_q));
    clh      = ceil_log2(32'(height_q));
    ga_c     = (clw > 6'(SUBTILE_LOG2)) ? 5'(clw - 6'(SUBTILE_LOG2)) : 5'd0;
    gb_c     = (clh > 6'(SUBTILE_LOG2)) ? 5'(clh - 6'(SUBTILE_LOG2)) : 5'd0;
  end

  // stage 2: derived geometry, settled one cycle after capture
  always_ff @(posedge clk) begin
    if (rst) begin
      tw_q        <= '0;
      th_q        <= '0;
      tpr_q       <= '0;
      ga_q        <= '0;
      gb_q        <= '0;
      stride_q    <= '0;
      body_q      <= '0;
      meta_base_q <= '0;
    end else begin
      tw_q        <= tw_c;
      th_q        <= th_c;
      tpr_q       <= tpr_c;
      ga_q        <= ga_c;
      gb_q        <= gb_c;
      stride_q    <= (DIM_W+4)'(width_q) << code_q;
      body_q      <= body_c;
      meta_base_q <= base_q + body_c;
    end
  end

endmodule

// File: rtl/tmap_walk.sv
module tmap_walk
  import tmap_pkg::*;
#(
  parameter int DIM_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ALIGN_LOG2-1:0] in_base_lo,
  input  logic [2:0]       in_code,
  input  logic [DIM_W-1:0] in_width,
  input  logic [DIM_W-1:0] in_height,
  input  logic [DIM_W-1:0] width_q,
  input  logic [DIM_W-1:0] height_q,
  input  logic             out_ready,
  output logic             load,
  output logic             adv,
  output logic             last_px,
  output logic [DIM_W-1:0] x,
  output logic [DIM_W-1:0] y,
  output logic             vld,
  output logic             busy,
  output logic             err
);

  walk_st_e st;
  logic     req_ok;
  logic     x_end;

  assign req_ok  = (in_base_lo == '0) && (in_code <= CODE_MAX) &&
                   (in_width != '0) && (in_height != '0);
  assign load    = start && (st == ST_IDLE) && req_ok;
  assign adv     = (st == ST_RUN) && (!vld || out_ready);
  assign x_end   = (x == width_q - DIM_W'(1));
  assign last_px = x_end && (y == height_q - DIM_W'(1));
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      x   <= '0;
      y   <= '0;
      vld <= 1'b0;
      err <= 1'b0;
    end else begin
      if (adv)            vld <= 1'b1;
      else if (out_ready) vld <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (req_ok) begin
              st  <= ST_SETUP;
              x   <= '0;
              y   <= '0;
              err <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_SETUP: st <= ST_RUN;
        ST_RUN: begin
          if (adv) begin
            if (last_px) st <= ST_DRAIN;
            else if (x_end) begin
              x <= '0;
              y <= y + DIM_W'(1);
            end else begin
              x <= x + DIM_W'(1);
            end
          end
        end
        default: begin
          if (vld && out_ready) st <= ST_IDLE;
        end
      endcase
    end
  end

  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (rst)
    vld && !out_ready |=> vld); // R4
  AST_ERR_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy); // R5
  AST_NO_BEAT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !vld); // R3

endmodule

// File: rtl/tmap_addr.sv
module tmap_addr
  import tmap_pkg::*;
#(
  parameter int DIM_W  = 13,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              vld,
  input  logic              out_ready,
  input  logic [DIM_W-1:0]  x,
  input  logic [DIM_W-1:0]  y,
  input  logic              last_px,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [2:0]        code_q,
  input  logic              comp_q,
  input  logic [2:0]        tw_q,
  input  logic [2:0]        th_q,
  input  logic [DIM_W-1:0]  tpr_q,
  input  logic [4:0]        ga_q,
  input  logic [4:0]        gb_q,
  input  logic [ADDR_W-1:0] meta_base_q,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_meta,
  output logic              out_last
);

  localparam int PROD_W = 2 * DIM_W;

  logic [DIM_W-1:0]             tx, ty;
  logic [PROD_W-1:0]            tidx;
  logic [2*SIDE_MAX_LOG2-1:0]   zin;
  logic [2*GRID_BITS-1:0]       zsub;
  logic [ADDR_W-1:0]            pix_c, meta_c;

  always_comb begin
    tx     = x >> tw_q;
    ty     = y >> th_q;
    tidx   = PROD_W'(ty) * PROD_W'(tpr_q) + PROD_W'(tx);
    zin    = tile_zorder(x[SIDE_MAX_LOG2-1:0], y[SIDE_MAX_LOG2-1:0], tw_q, th_q);
    pix_c  = base_q + (ADDR_W'(tidx) << TILE_BYTES_LOG2) + (ADDR_W'(zin) << code_q);
    zsub   = grid_zorder(GRID_BITS'(x >> SUBTILE_LOG2), GRID_BITS'(y >> SUBTILE_LOG2),
                         ga_q, gb_q);
    meta_c = comp_q ? (meta_base_q + (ADDR_W'(zsub) << META_ENTRY_LOG2)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_meta <= '0;
      out_last <= 1'b0;
    end else if (adv) begin
      out_addr <= pix_c;
      out_meta <= meta_c;
      out_last <= last_px;
    end
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    vld && !out_ready |=> $stable(out_addr) && $stable(out_meta) && $stable(out_last)); // R4
  AST_PIX_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    vld |-> ((out_addr & ((ADDR_W'(1) << code_q) - ADDR_W'(1))) == '0)); // R1
  AST_META_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    vld |-> (out_meta[META_ENTRY_LOG2-1:0] == '0)); // R10
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    vld && out_last |-> !adv); // R3

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tmap_pkg::*;
#(
  parameter int DIM_W  = 13,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [2:0]        cfg_bpp_code,
  input  logic              cfg_compressed,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic              busy,
  output logic              cfg_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_meta,
  output logic              out_last,
  output logic [DIM_W+3:0]  geo_stride,
  output logic [ADDR_W-1:0] geo_body_size,
  output logic [ADDR_W-1:0] geo_meta_base
);

  logic              load, adv, last_px;
  logic [DIM_W-1:0]  x, y, width_q, height_q, tpr_q;
  logic [2:0]        code_q, tw_q, th_q;
  logic              comp_q;
  logic [ADDR_W-1:0] base_q;
  logic [4:0]        ga_q, gb_q;

  tmap_geom #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) geom_i (
    .clk(clk), .rst(rst), .load(load),
    .in_width(cfg_width), .in_height(cfg_height), .in_code(cfg_bpp_code),
    .in_comp(cfg_compressed), .in_base(cfg_base),
    .width_q(width_q), .height_q(height_q), .code_q(code_q), .comp_q(comp_q),
    .base_q(base_q), .tw_q(tw_q), .th_q(th_q), .tpr_q(tpr_q),
    .ga_q(ga_q), .gb_q(gb_q), .stride_q(geo_stride),
    .body_q(geo_body_size), .meta_base_q(geo_meta_base)
  );

  tmap_walk #(.DIM_W(DIM_W)) walk_i (
    .clk(clk), .rst(rst), .start(start),
    .in_base_lo(cfg_base[ALIGN_LOG2-1:0]), .in_code(cfg_bpp_code),
    .in_width(cfg_width), .in_height(cfg_height),
    .width_q(width_q), .height_q(height_q), .out_ready(out_ready),
    .load(load), .adv(adv), .last_px(last_px), .x(x), .y(y),
    .vld(out_valid), .busy(busy), .err(cfg_err)
  );

  tmap_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst(rst), .adv(adv), .vld(out_valid), .out_ready(out_ready),
    .x(x), .y(y), .last_px(last_px),
    .base_q(base_q), .code_q(code_q), .comp_q(comp_q), .tw_q(tw_q), .th_q(th_q),
    .tpr_q(tpr_q), .ga_q(ga_q), .gb_q(gb_q), .meta_base_q(geo_meta_base),
    .out_addr(out_addr), .out_meta(out_meta), .out_last(out_last)
  );

  AST_GEOM_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && $past(busy, 2) |-> $stable(geo_stride) && $stable(geo_meta_base)); // R7

endmodule

// File: tb/tile_addr_gen_tb_top.sv
module tile_addr_gen_tb_top;

  localparam int DIM_W  = 13;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [DIM_W-1:0]  cfg_width = '0;
  logic [DIM_W-1:0]  cfg_height = '0;
  logic [2:0]        cfg_bpp_code = '0;
  logic              cfg_compressed = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic              busy, cfg_err, out_valid, out_last;
  logic              out_ready = 1'b0;
  logic [ADDR_W-1:0] out_addr, out_meta, geo_body_size, geo_meta_base;
  logic [DIM_W+3:0]  geo_stride;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  tile_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_bpp_code(cfg_bpp_code),
    .cfg_compressed(cfg_compressed), .cfg_base(cfg_base),
    .busy(busy), .cfg_err(cfg_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_meta(out_meta), .out_last(out_last),
    .geo_stride(geo_stride), .geo_body_size(geo_body_size), .geo_meta_base(geo_meta_base)
  );

  function automatic void check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic int lg(longint v);
    int r = 0;
    while ((64'd1 << r) < v) r++;
    return r;
  endfunction

  // take bits alternately from x then y, skipping a side once it runs out
  function automatic longint zord(longint x, longint y, int nx, int ny);
    longint r = 0;
    int pos = 0, ix = 0, iy = 0;
    while (ix < nx || iy < ny) begin
      if (ix < nx) begin r |= ((x >> ix) & 1) << pos; pos++; ix++; end
      if (iy < ny) begin r |= ((y >> iy) & 1) << pos; pos++; iy++; end
    end
    return r;
  endfunction

  function automatic int tile_w(int code);
    case (code) 0, 1: return 128; 2, 3: return 64; default: return 32; endcase
  endfunction
  function automatic int tile_h(int code);
    case (code) 0: return 128; 1, 2: return 64; default: return 32; endcase
  endfunction

  function automatic longint body_of(int w, int h, int code);
    longint b;
    int tw = tile_w(code), th = tile_h(code);
    b = longint'((w + tw - 1) / tw) * longint'((h + th - 1) / th) * 16384;
    return ((b + 127) / 128) * 128;
  endfunction

  function automatic longint exp_pix(int w, int code, longint base, int x, int y);
    int tw = tile_w(code), th = tile_h(code);
    longint t = longint'(y / th) * longint'((w + tw - 1) / tw) + longint'(x / tw);
    return base + t * 16384 + zord(x % tw, y % th, lg(tw), lg(th)) * (64'd1 << code);
  endfunction

  function automatic longint exp_meta(int w, int h, int code, bit comp, longint base,
                                      int x, int y);
    int a = lg(w) - 4, b = lg(h) - 4;
    if (!comp) return 0;
    if (a < 0) a = 0;
    if (b < 0) b = 0;
    return base + body_of(w, h, code) + zord(x / 16, y / 16, a, b) * 8;
  endfunction

  task automatic pulse_start(int w, int h, int code, bit comp, longint base);
    @(negedge clk);
    cfg_width = DIM_W'(w); cfg_height = DIM_W'(h); cfg_bpp_code = 3'(code);
    cfg_compressed = comp; cfg_base = ADDR_W'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // mode 0: always ready; mode 1: ready low every third cycle
  task automatic consume(int w, int h, int code, bit comp, longint base, int mode,
                         int px, int py, output longint p_addr, output longint p_meta);
    int k = 0, cyc = 0, bad_ord = 0;
    bit stall = 0, rdy;
    longint ha = 0, hm = 0;
    bit hl = 0;
    p_addr = -1; p_meta = -1;
    while (k < w * h) begin
      @(negedge clk);
      if (stall)
        check(out_valid && out_addr == ADDR_W'(ha) && out_meta == ADDR_W'(hm) && out_last == hl,
              "R4 hold", out_addr, ha);
      rdy = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      out_ready = rdy;
      if (out_valid && rdy) begin
        int x = k % w, y = k / w;
        if (out_addr != ADDR_W'(exp_pix(w, code, base, x, y))) begin
          bad_ord++;
          check(0, "R1 pixel address", out_addr, exp_pix(w, code, base, x, y));
        end
        if (out_meta != ADDR_W'(exp_meta(w, h, code, comp, base, x, y))) begin
          bad_ord++;
          check(0, "R10 metadata address", out_meta, exp_meta(w, h, code, comp, base, x, y));
        end
        if (out_last != (k == w * h - 1)) begin
          bad_ord++;
          check(0, "R3 last flag", out_last, (k == w * h - 1));
        end
        if (x == px && y == py) begin p_addr = out_addr; p_meta = out_meta; end
        k++;
      end
      stall = out_valid && !rdy;
      ha = out_addr; hm = out_meta; hl = out_last;
      cyc++;
    end
    check(bad_ord == 0, "R3 raster stream matches", bad_ord, 0);
    @(negedge clk);
    out_ready = 1'b0;
    check(!busy && !out_valid, "R3 done after last beat", {busy, out_valid}, 0);
    check(geo_stride == (DIM_W+4)'(w << code), "R8 stride", geo_stride, w << code);
    check(geo_body_size == ADDR_W'(body_of(w, h, code)), "R9 body size",
          geo_body_size, body_of(w, h, code));
    check(geo_meta_base == ADDR_W'(base + body_of(w, h, code)), "R9 meta base",
          geo_meta_base, base + body_of(w, h, code));
  endtask

  task automatic t_reset();
    check(!out_valid && !busy && !cfg_err, "R11 reset state", {out_valid, busy, cfg_err}, 0);
  endtask

  task automatic t_small_plain();
    longint a, m;
    pulse_start(5, 3, 0, 0, 'h1000);
    consume(5, 3, 0, 0, 'h1000, 0, 1, 1, a, m);
    check(a == 'h1003, "R2 in-tile (1,1) index 3", a, 'h1003);
    check(m == 0, "R10 plain layout meta is zero", m, 0);
  endtask

  task automatic t_square16();
    longint a, m;
    pulse_start(40, 36, 4, 1, 'h80);
    consume(40, 36, 4, 1, 'h80, 1, 33, 17, a, m);
    check(a == 'h60B0, "R1 second tile 16B pixel", a, 'h60B0);
    check(m == 'h100B0, "R10 subtile (2,1)", m, 'h100B0);
  endtask

  task automatic t_rect2();
    longint a, m;
    pulse_start(130, 66, 1, 1, 'h20000);
    consume(130, 66, 1, 1, 'h20000, 0, 127, 0, a, m);
    check(a == 'h22AAA, "R2 leftover x bit on top", a, 'h22AAA);
    check(m == 'h300A8, "R10 non-square grid", m, 'h300A8);
  endtask

  task automatic t_mid_sizes();
    longint a, m;
    pulse_start(70, 10, 2, 1, 'h400);
    consume(70, 10, 2, 1, 'h400, 1, 65, 3, a, m);
    check(a == ADDR_W'(exp_pix(70, 2, 'h400, 65, 3)), "R1 4B pixel", a,
          exp_pix(70, 2, 'h400, 65, 3));
    pulse_start(10, 40, 3, 0, 'h8000);
    consume(10, 40, 3, 0, 'h8000, 1, 3, 33, a, m);
    check(a == ADDR_W'(exp_pix(10, 3, 'h8000, 3, 33)), "R1 8B pixel", a,
          exp_pix(10, 3, 'h8000, 3, 33));
  endtask

  task automatic watch_idle(string req);
    int seen = 0;
    out_ready = 1'b1;
    repeat (8) begin @(negedge clk); if (out_valid || busy) seen++; end
    out_ready = 1'b0;
    check(seen == 0, req, seen, 0);
  endtask

  task automatic t_err_align();
    pulse_start(8, 8, 2, 0, 'h40);
    check(cfg_err && !busy, "R5 misaligned base refused", {cfg_err, busy}, 2);
    watch_idle("R5 no beats after refusal");
  endtask

  task automatic t_err_cfg();
    pulse_start(8, 8, 5, 0, 'h0);
    check(cfg_err && !busy, "R6 bad size code refused", {cfg_err, busy}, 2);
    watch_idle("R6 no beats after bad code");
    pulse_start(0, 8, 2, 0, 'h0);
    check(cfg_err && !busy, "R6 zero width refused", {cfg_err, busy}, 2);
    pulse_start(8, 0, 2, 0, 'h0);
    check(cfg_err && !busy, "R6 zero height refused", {cfg_err, busy}, 2);
  endtask

  task automatic t_busy_start();
    longint a, m;
    out_ready = 1'b0;
    pulse_start(10, 4, 3, 0, 'h4000);
    check(!cfg_err && busy, "R5 accepted start clears error", {cfg_err, busy}, 1);
    repeat (4) @(negedge clk);
    pulse_start(3, 3, 0, 1, 'h100);
    check(busy && !cfg_err, "R7 start while busy ignored", {busy, cfg_err}, 2);
    consume(10, 4, 3, 0, 'h4000, 1, 9, 3, a, m);
    check(a == ADDR_W'(exp_pix(10, 3, 'h4000, 9, 3)), "R7 walk kept its config", a,
          exp_pix(10, 3, 'h4000, 9, 3));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_small_plain();
    t_square16();
    t_rect2();
    t_mid_sizes();
    t_err_align();
    t_err_cfg();
    t_busy_start();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule